// File: doc/BRIEF.md
# Dual-Edge Adaptive Synchronous Rectifier Gate Predictor

This block produces the two gate enables for the secondary-side synchronous rectifiers of a half-bridge resonant converter. An analog comparator cannot switch a rectifier gate early enough by itself. The block therefore predicts each rectifier's turn-off point from timing it measured during the previous switching half-period of the same phase. It uses two independent time references. The first is the length of the rectifier's conduction interval. The second is how far the conduction ran past the falling edge of the matching primary gate.

For each phase, the next half-period builds two windows. The first is a length window. It opens at the primary rising edge and stays open for the measured conduction length. The second is an edge window. It follows the primary gate, and it is stretched past the primary falling edge when the converter ran above resonance. The gate enable is the AND of the two windows. The stretch value has a fixed detection latency removed from it. All timing is counted in ticks of the block clock (one tick is 25 ns at 40 MHz), using saturating counters.

The following conditions suppress the drive globally. The gate is forced off in PWM (burst) mode. A hysteretic light-load enable gates the drive, and it is built from two peak-current comparator flags. A shrink flag pulls both gate edges inward, which widens the dead time.

Top module: `sr_gate_predictor`

## Requirements
- R1: A phase's gate samples the cycle after a primary rising edge is sampled (index k = 0). With no shrink and a primary gate that outlasts it, the gate stays high for exactly L consecutive samples. L is the previous half-period's end-flag sample index minus its start-flag sample index.
- R2: If the previous conduction ended at or before the primary falling edge, the gate goes low at the first sample where the primary gate is low, even when L is longer.
- R3: Let the previous conduction end E samples after the primary falling sample, with E greater than DLY_TICKS. The gate then stays high for E minus DLY_TICKS samples past the primary falling sample, bounded by R1.
- R4: The gate is the AND of both windows. It ends at whichever window closes first.
- R5: If E is at most DLY_TICKS, the detection latency absorbs the stretch, and the gate ends with the primary gate.
- R6: While pwm_mode is sampled high, both gates are low on the following sample. Measurement continues, so the first half-period after pwm_mode drops already uses the full window.
- R7: Drive is disabled whenever pk_above_lo is low. Once disabled, it re-enables only when pk_above_hi is high. It stays disabled while pk_above_lo is high but pk_above_hi is low. The enable is low after reset.
- R8: With shrink high, the gate opens SHRINK_TICKS samples after the rising sample and closes SHRINK_TICKS samples before the length window would end.
- R9: After reset, and after any half-period with a start flag but no later end flag, that phase's gate stays low for the whole next half-period.
- R10: Each phase uses only its own primary gate and flags. Its last measurement is kept while the other phase switches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one tick per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| pri_gate | input | N_PH | Primary gate level per phase |
| cond_start | input | N_PH | One-sample flag: rectifier conduction began |
| cond_end | input | N_PH | One-sample flag: rectifier conduction ended |
| pwm_mode | input | 1 | Converter is in PWM (burst) mode; forces gates off |
| pk_above_lo | input | 1 | Integrated-current peak is above the low threshold |
| pk_above_hi | input | 1 | Integrated-current peak is above the high threshold |
| shrink | input | 1 | Widen dead time at both gate edges |
| sr_gate | output | N_PH | Rectifier gate enables |

## Verification
A primary rising edge does two jobs in the same sample. It commits the previous half-period's measurement, and it restarts the measurement, which may include a conduction-start flag arriving in that very sample. The bench provokes this by putting the start flag on the rising-edge sample (index 0). It then judges the following half-period: the gate width there must equal the end index. A second overlap occurs when the length window and the stretched edge window each limit the gate in turn. The bench provokes it with back-to-back half-periods, one where the edge window is shorter and one where the length window is shorter. It compares every sample against a per-sample scoreboard.

// File: rtl/sr_pred_pkg.sv
package sr_pred_pkg;
    localparam int DEF_CNT_W = 10;

    typedef enum logic {
        REGIME_BELOW = 1'b0,
        REGIME_ABOVE = 1'b1
    } regime_e;
endpackage

// File: rtl/sr_enable_hyst.sv
module sr_enable_hyst (
    input  logic clk,
    input  logic rst_n,
    input  logic above_lo_i,
    input  logic above_hi_i,
    output logic en_now_o
);
    typedef struct packed {
        logic en;
    } hyst_t;

    hyst_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!above_lo_i)
            st_d.en = 1'b0;
        else if (above_hi_i)
            st_d.en = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_now_o = st_d.en;

    // R7
    no_reenable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en && !above_hi_i) |=> !st_q.en);
endmodule

// File: rtl/sr_phase_pred.sv
module sr_phase_pred
    import sr_pred_pkg::*;
#(
    parameter int CW  = DEF_CNT_W,
    parameter int DLY = 4,
    parameter int SHR = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pri_i,
    input  logic cstart_i,
    input  logic cend_i,
    input  logic enable_i,
    input  logic force_off_i,
    input  logic shrink_i,
    output logic gate_o
);
    localparam logic [CW-1:0] CMAX  = '1;
    localparam logic [CW-1:0] DLY_C = CW'(DLY);
    localparam logic [CW:0]   SHR_X = (CW+1)'(SHR);

    typedef struct packed {
        logic          pri;
        logic [CW-1:0] age;
        logic          active;
        logic          end_seen;
        logic [CW-1:0] lcnt;
        logic          fell;
        logic [CW-1:0] ecnt;
        logic [CW-1:0] ext_raw;
        logic [CW-1:0] len;
        logic [CW-1:0] ext;
        logic          valid;
        logic          gate;
    } ph_t;

    ph_t st_q, st_d;

    function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
        return (v == CMAX) ? v : v + 1'b1;
    endfunction

    logic    rise, fall, win_len, win_edge;
    logic [CW:0] age_x, len_x;
    regime_e regime;

    always_comb begin
        st_d = st_q;
        rise = pri_i && !st_q.pri;
        fall = !pri_i && st_q.pri;
        st_d.pri = pri_i;

        // commit last half-period and restart the measurement
        if (rise) begin
            st_d.len      = st_q.lcnt;
            st_d.ext      = (st_q.ext_raw > DLY_C) ? st_q.ext_raw - DLY_C : '0;
            st_d.valid    = st_q.end_seen;
            st_d.end_seen = 1'b0;
            st_d.active   = 1'b0;
            st_d.fell     = 1'b0;
            st_d.lcnt     = '0;
            st_d.ext_raw  = '0;
            st_d.age      = '0;
        end else begin
            st_d.age = sat_inc(st_q.age);
        end

        // conduction interval measurement
        if (st_d.active) begin
            st_d.lcnt = sat_inc(st_d.lcnt);
            if (cend_i) begin
                st_d.active   = 1'b0;
                st_d.end_seen = 1'b1;
                st_d.ext_raw  = st_d.fell ? sat_inc(st_d.ecnt) : '0;
            end
        end else if (cstart_i && !st_d.end_seen) begin
            st_d.active = 1'b1;
            st_d.lcnt   = '0;
        end

        // time since primary falling edge
        if (fall) begin
            st_d.fell = 1'b1;
            st_d.ecnt = '0;
        end else if (st_d.fell) begin
            st_d.ecnt = sat_inc(st_d.ecnt);
        end

        // window from conduction length
        age_x = {1'b0, st_d.age};
        len_x = {1'b0, st_d.len};
        if (shrink_i)
            win_len = (age_x >= SHR_X) && ((age_x + SHR_X) < len_x);
        else
            win_len = age_x < len_x;

        // window from primary edge, stretched above resonance
        regime   = (st_d.ext != '0) ? REGIME_ABOVE : REGIME_BELOW;
        win_edge = pri_i ||
                   ((regime == REGIME_ABOVE) && st_d.fell && (st_d.ecnt < st_d.ext));

        st_d.gate = st_d.valid && enable_i && !force_off_i && win_len && win_edge;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gate_o = st_q.gate;

    // width checker: consecutive high samples within a half-period
    logic [CW-1:0] hi_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hi_run_q <= '0;
        else if (!st_q.gate)
            hi_run_q <= '0;
        else if (st_q.age == '0)
            hi_run_q <= CW'(1);
        else
            hi_run_q <= sat_inc(hi_run_q);
    end

    // R1
    width_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.gate && st_q.age != '0) |-> (hi_run_q < st_q.len));

    // R1
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.age == CMAX && !(pri_i && !st_q.pri)) |=> (st_q.age == CMAX));

    // R9
    invalid_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_i && !st_q.pri && !st_q.end_seen) |=> !gate_o);
endmodule

// File: rtl/sr_gate_predictor.sv
module sr_gate_predictor
    import sr_pred_pkg::*;
#(
    parameter int N_PH         = 2,
    parameter int CW           = DEF_CNT_W,
    parameter int DLY_TICKS    = 4,
    parameter int SHRINK_TICKS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_PH-1:0] pri_gate,
    input  logic [N_PH-1:0] cond_start,
    input  logic [N_PH-1:0] cond_end,
    input  logic            pwm_mode,
    input  logic            pk_above_lo,
    input  logic            pk_above_hi,
    input  logic            shrink,
    output logic [N_PH-1:0] sr_gate
);
    logic drive_en;

    sr_enable_hyst u_hyst (
        .clk        (clk),
        .rst_n      (rst_n),
        .above_lo_i (pk_above_lo),
        .above_hi_i (pk_above_hi),
        .en_now_o   (drive_en)
    );

    for (genvar p = 0; p < N_PH; p++) begin : g_phase
        sr_phase_pred #(
            .CW  (CW),
            .DLY (DLY_TICKS),
            .SHR (SHRINK_TICKS)
        ) u_phase (
            .clk         (clk),
            .rst_n       (rst_n),
            .pri_i       (pri_gate[p]),
            .cstart_i    (cond_start[p]),
            .cend_i      (cond_end[p]),
            .enable_i    (drive_en),
            .force_off_i (pwm_mode),
            .shrink_i    (shrink),
            .gate_o      (sr_gate[p])
        );
    end

    // R6
    pwm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_mode |=> (sr_gate == '0));

    // R7
    light_load_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pk_above_lo |=> (sr_gate == '0));
endmodule

// File: tb/sr_gate_predictor_tb.sv
`timescale 1ns/1ps
module sr_gate_predictor_tb;
    localparam int NP  = 2;
    localparam int DLY = 4;
    localparam int SH  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pri = '0, cs = '0, ce = '0;
    logic          pwm = 1'b0, lo = 1'b0, hi = 1'b0, shr = 1'b0;
    logic [NP-1:0] sr_gate;

    always #2.5 clk = ~clk;

    sr_gate_predictor #(.N_PH(NP), .CW(10), .DLY_TICKS(DLY), .SHRINK_TICKS(SH)) u_dut (
        .clk(clk), .rst_n(rst_n), .pri_gate(pri), .cond_start(cs), .cond_end(ce),
        .pwm_mode(pwm), .pk_above_lo(lo), .pk_above_hi(hi), .shrink(shr),
        .sr_gate(sr_gate)
    );

    typedef struct {
        int    cyc;
        int    ch;
        bit    exp;
        string tag;
    } item_t;

    item_t sb[$];
    int    smp = 0;
    int    n_tests = 0, n_fail = 0;
    bit    done = 1'b0;

    // bench model of previous-half-period measurement per phase
    bit m_valid[NP];
    int m_len[NP];
    int m_ext[NP];
    bit m_en = 1'b0;

    always @(posedge clk) smp <= smp + 1;

    // monitor
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc <= smp) begin
            item_t it;
            it = sb.pop_front();
            n_tests++;
            if (sr_gate[it.ch] !== it.exp) begin
                n_fail++;
                $display("FAIL %s ch%0d sample %0d: got %0b expected %0b",
                         it.tag, it.ch, it.cyc, sr_gate[it.ch], it.exp);
            end
        end
    end

    function automatic bit model_gate(int c, int k, int hlen, bit sh);
        bit w1, w2;
        if (sh) w1 = (k >= SH) && (k + SH < m_len[c]);
        else    w1 = k < m_len[c];
        w2 = (k < hlen) || (m_ext[c] > 0 && k >= hlen && (k - hlen) < m_ext[c]);
        return m_valid[c] && w1 && w2;
    endfunction

    task automatic push(int cyc, int ch, bit e, string tag);
        item_t it;
        it.cyc = cyc; it.ch = ch; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(int n, string tag);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            pri = '0; cs = '0; ce = '0;
            for (int c = 0; c < NP; c++) push(smp + 1, c, 1'b0, tag);
        end
    endtask

    // one half-period of phase ch: primary high for hlen of per samples
    task automatic run(int ch, int hlen, int per, int s_idx, int e_idx,
                       bit sh, bit pw, bit l, bit h, string tag);
        int raw;
        for (int k = 0; k < per; k++) begin
            @(negedge clk);
            pri = '0; cs = '0; ce = '0;
            pri[ch] = (k < hlen);
            cs[ch]  = (k == s_idx);
            ce[ch]  = (k == e_idx);
            shr = sh; pwm = pw; lo = l; hi = h;
            if (!l) m_en = 1'b0;
            else if (h) m_en = 1'b1;
            for (int c = 0; c < NP; c++)
                push(smp + 1, c,
                     (c == ch) && m_en && !pw && model_gate(c, k, hlen, sh), tag);
        end
        m_valid[ch] = (s_idx >= 0) && (e_idx > s_idx);
        m_len[ch]   = e_idx - s_idx;
        raw         = (e_idx > hlen) ? e_idx - hlen : 0;
        m_ext[ch]   = (raw > DLY) ? raw - DLY : 0;
    endtask

    initial begin
        for (int c = 0; c < NP; c++) begin
            m_valid[c] = 1'b0; m_len[c] = 0; m_ext[c] = 0;
        end
        repeat (4) @(negedge clk);
        // R9: reset state
        n_tests++;
        if (sr_gate !== '0) begin
            n_fail++;
            $display("FAIL R9 reset: got %b expected 00", sr_gate);
        end
        rst_n = 1'b1;
        idle(5, "R9");
        run(0, 20, 40, 1, 12, 0, 0, 1, 1, "R9");   // no prior measurement
        run(0, 20, 40, 1, 12, 0, 0, 1, 1, "R1");   // width 11
        run(0,  8, 40, 1, 14, 0, 0, 1, 1, "R2");   // cut at primary fall
        run(0,  8, 40, 1, 18, 0, 0, 1, 1, "R3");   // stretch 2 past fall
        run(0,  8, 40, 8, 18, 0, 0, 1, 1, "R4");   // edge window shorter
        run(0,  8, 40, 1, 12, 0, 0, 1, 1, "R4");   // length window shorter
        run(0,  8, 40, 1, 12, 0, 0, 1, 1, "R5");   // stretch absorbed by latency
        run(0, 20, 40, 1, 12, 1, 0, 1, 1, "R8");   // shrink both edges
        run(0, 20, 40, 1, 12, 0, 1, 1, 1, "R6");   // PWM forces off
        run(0, 20, 40, 1, 12, 0, 0, 1, 1, "R6");   // measurement kept
        run(0, 20, 40, 1, 12, 0, 0, 1, 0, "R7");   // between thresholds: hold on
        run(0, 20, 40, 1, 12, 0, 0, 0, 0, "R7");   // below low: off
        run(0, 20, 40, 1, 12, 0, 0, 1, 0, "R7");   // between: stays off
        run(0, 20, 40, 1, 12, 0, 0, 1, 1, "R7");   // above high: on
        run(0, 20, 40, 1, -1, 0, 0, 1, 1, "R9");   // no end flag
        run(0, 20, 40, 0, 11, 0, 0, 1, 1, "R9");   // off; start at rising sample
        run(0, 20, 40, 1, 12, 0, 0, 1, 1, "R1");   // width 11 from start-at-rise
        run(1, 20, 40, 2,  9, 0, 0, 1, 1, "R10");
        run(1, 20, 40, 2,  9, 0, 0, 1, 1, "R10");
        run(1,  6, 40, 2, 16, 0, 0, 1, 1, "R10");
        run(1,  6, 40, 2, 16, 0, 0, 1, 1, "R10");
        run(0, 20, 40, 1, 12, 0, 0, 1, 1, "R10");  // phase 0 retained
        idle(4, "R10");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule